// File: doc/BRIEF.md
# Program Store with Instruction Counter

This block holds the instruction words of a small processor and the counter that points at the next one to run. The store has 256 words of 16 bits, reached through an 8-bit address. The upper four address bits drive a one-hot row decode and the lower four drive a one-hot column decode. A word is selected only where its row line and its column line are both active. While the write strobe is high, the value on the shared bus is captured into the selected word on the rising clock edge. The selected word is always presented on the read output, with no clock between the address and the data.

The instruction counter sits next to the store. It clears to zero on reset. It can be loaded from the low byte of the bus. It advances by one when the sequencing logic reports that an instruction has finished. The bus arbitration that chooses the store's address, and the sequencing logic itself, are outside this block.

Top module: `prog_store_top`

## Requirements
- R1: While `rst_n` is low the counter output `pc_value` is 0, and it goes to 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: When `wr_en` is high at a rising clock edge, the word at `mem_addr` takes the value of `bus_data` from that edge onward.
- R3: `rd_data` shows the word stored at `mem_addr`, and it follows a change of address before the next clock edge.
- R4: When `wr_en` is low at a clock edge, no stored word changes, whatever value `bus_data` carries.
- R5: With `pc_load` low and `done` high at a clock edge, `pc_value` becomes its previous value plus one.
- R6: With `pc_load` and `done` both low, `pc_value` keeps its value across clock edges.
- R7: With `pc_load` high at a clock edge, `pc_value` becomes `bus_data[7:0]`.
- R8: When `pc_load` and `done` are both high at the same edge, the load wins and the increment is dropped.
- R9: The counter is 8 bits wide, so an increment from 255 gives 0.
- R10: A write changes only the one word whose row (address bits 7:4) and column (address bits 3:0) both match. Words that share only the row or only the column are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | input | 8 | Word address: bits 7:4 select the row, bits 3:0 select the column |
| wr_en | input | 1 | Write strobe for the store |
| bus_data | input | 16 | Shared bus value: write data, and the counter load value in its low byte |
| rd_data | output | 16 | Word at `mem_addr`, combinational |
| pc_load | input | 1 | Load the counter from `bus_data[7:0]` |
| done | input | 1 | Instruction-finished pulse that advances the counter |
| pc_value | output | 8 | Current counter value |

## Verification
The properties are disabled until the internal reset has been released. After that point they assume that every input is a clean level, stable around each rising edge. They also assume that no word is read back before it has been written, because stored words have no reset value. The stimulus changes inputs only on falling edges. It writes all 256 words before the first read, and it drives `done` and `pc_load` only after the synchronizer has let go of reset.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  parameter int unsigned ADDR_W = 8;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned PC_W   = 8;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int unsigned IN_W = 4
) (
  input  logic [IN_W-1:0]      code,
  output logic [(1<<IN_W)-1:0] lines
);
  localparam int unsigned N_LINES = 1 << IN_W;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign lines[i] = (code == IN_W'(i));
  end
endmodule

// File: rtl/word_grid.sv
module word_grid #(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic [(1<<SEL_W)-1:0] row_sel,
  input  logic [(1<<SEL_W)-1:0] col_sel,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  localparam int unsigned ROWS  = 1 << SEL_W;
  localparam int unsigned COLS  = 1 << SEL_W;
  localparam int unsigned CELLS = ROWS * COLS;

  logic [CELLS-1:0][DATA_W-1:0] gated;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic              hit;
      logic              cell_we;
      logic [DATA_W-1:0] cell_q;
      logic [DATA_W-1:0] cell_d;

      assign hit     = row_sel[r] & col_sel[c];
      assign cell_we = wr_en & hit;

      always_comb begin
        cell_d = cell_q;
        if (cell_we) cell_d = wdata;
      end

      always_ff @(posedge clk) begin
        cell_q <= cell_d;
      end

      assign gated[r*COLS+c] = cell_q & {DATA_W{hit}};
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < CELLS; k++) rdata = rdata | gated[k];
  end
endmodule

// File: rtl/instr_counter.sv
module instr_counter #(
  parameter int unsigned PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] count
);
  logic [PC_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (load)      count_d = load_val;
    else if (step) count_d = count + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/prog_store_top.sv
module prog_store_top
  import pmem_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned CW    = PC_W,
  parameter int unsigned SYNCN = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mem_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] rd_data,
  input  logic          pc_load,
  input  logic          done,
  output logic [CW-1:0] pc_value
);
  localparam int unsigned HALF_W = AW / 2;
  localparam int unsigned LINES  = 1 << HALF_W;

  logic [SYNCN-1:0] rst_pipe;
  logic             rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNCN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNCN-1];

  logic [LINES-1:0] row_lines;
  logic [LINES-1:0] col_lines;

  onehot_dec #(.IN_W(HALF_W)) i_row_dec (
    .code  (mem_addr[AW-1:HALF_W]),
    .lines (row_lines)
  );

  onehot_dec #(.IN_W(HALF_W)) i_col_dec (
    .code  (mem_addr[HALF_W-1:0]),
    .lines (col_lines)
  );

  word_grid #(.SEL_W(HALF_W), .DATA_W(DW)) i_grid (
    .clk     (clk),
    .row_sel (row_lines),
    .col_sel (col_lines),
    .wr_en   (wr_en),
    .wdata   (bus_data),
    .rdata   (rd_data)
  );

  instr_counter #(.PC_W(CW)) i_pc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (pc_load),
    .step     (done),
    .load_val (bus_data[CW-1:0]),
    .count    (pc_value)
  );
endmodule

// File: rtl/prog_store_checker.sv
module prog_store_checker #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_int_n,
  input logic [AW-1:0] mem_addr,
  input logic          wr_en,
  input logic [DW-1:0] bus_data,
  input logic [DW-1:0] rd_data,
  input logic          pc_load,
  input logic          done,
  input logic [CW-1:0] pc_value
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_pc_zero_in_reset_r1: assert (pc_value == '0);
    end
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> (!$stable(mem_addr) || rd_data == $past(bus_data)));

  p_no_write_no_change_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |=> (!$stable(mem_addr) || $stable(rd_data)));

  p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !pc_load) |=> pc_value == CW'($past(pc_value) + 1'b1));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!done && !pc_load) |=> $stable(pc_value));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_load |=> pc_value == $past(bus_data[CW-1:0]));
endmodule

bind prog_store_top prog_store_checker #(.AW(AW), .DW(DW), .CW(CW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_sync_n),
  .mem_addr  (mem_addr),
  .wr_en     (wr_en),
  .bus_data  (bus_data),
  .rd_data   (rd_data),
  .pc_load   (pc_load),
  .done      (done),
  .pc_value  (pc_value)
);

// File: tb/test_prog_store_top.sv
`timescale 1ns/1ps
module test_prog_store_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  mem_addr;
  logic        wr_en;
  logic [15:0] bus_data;
  logic [15:0] rd_data;
  logic        pc_load;
  logic        done;
  logic [7:0]  pc_value;

  int n_run;
  int n_fail;

  prog_store_top i_prog_store_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .wr_en    (wr_en),
    .bus_data (bus_data),
    .rd_data  (rd_data),
    .pc_load  (pc_load),
    .done     (done),
    .pc_value (pc_value)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503) & 16'hFFFF) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int pexp;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; mem_addr = '0; wr_en = 1'b0; bus_data = '0;
    pc_load = 1'b0; done = 1'b0;
    repeat (5) @(negedge clk);
    chk(pc_value == 8'd0, "R1", pc_value, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pc_value == 8'd0, "R1", pc_value, 0);

    // R2: fill every word
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      mem_addr = 8'(a); wr_en = 1'b1; bus_data = pat(a);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R3: read without an edge between address change and sample
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      mem_addr = 8'(a);
      #1;
      chk(rd_data == pat(a), "R3", rd_data, pat(a));
    end

    // R4: strobe low, garbage on the bus, edges pass
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      mem_addr = 8'(a); bus_data = ~pat(a);
      @(posedge clk); #1;
      chk(rd_data == pat(a), "R4", rd_data, pat(a));
    end

    // R2 and R10: single write, then sweep
    @(negedge clk);
    mem_addr = 8'h37; bus_data = 16'h1234; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bus_data = 16'hFFFF;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      mem_addr = 8'(a);
      #1;
      if (a == 8'h37) chk(rd_data == 16'h1234, "R2", rd_data, 16'h1234);
      else            chk(rd_data == pat(a), "R10", rd_data, pat(a));
    end

    // R5 and R9: step through a full wrap
    pexp = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      done = 1'b1;
      @(posedge clk); #1;
      pexp = (pexp + 1) % 256;
      if (pexp == 0) chk(pc_value == 8'(pexp), "R9", pc_value, pexp);
      else           chk(pc_value == 8'(pexp), "R5", pc_value, pexp);
    end
    @(negedge clk);
    done = 1'b0;

    // R6: idle hold
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk(pc_value == 8'(pexp), "R6", pc_value, pexp);
    end

    // R7: load from low byte
    @(negedge clk);
    pc_load = 1'b1; bus_data = 16'hABFE;
    @(posedge clk); #1;
    chk(pc_value == 8'hFE, "R7", pc_value, 8'hFE);
    @(negedge clk);
    pc_load = 1'b0; done = 1'b1;
    @(posedge clk); #1;
    chk(pc_value == 8'hFF, "R5", pc_value, 8'hFF);
    @(posedge clk); #1;
    chk(pc_value == 8'h00, "R9", pc_value, 0);

    // R8: load and done together
    @(negedge clk);
    pc_load = 1'b1; done = 1'b1; bus_data = 16'h0010;
    @(posedge clk); #1;
    chk(pc_value == 8'h10, "R8", pc_value, 8'h10);
    @(negedge clk);
    pc_load = 1'b0; done = 1'b0;

    // R1: asynchronous clear mid-run
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk(pc_value == 8'd0, "R1", pc_value, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pc_value == 8'd0, "R1", pc_value, 0);

    finish_run();
  end
endmodule